// File: doc/BRIEF.md
# Byte-wide SPI controller with overflow and mode-fault detection

This block is an 8-bit serial peripheral port with a three-register host interface. A control register holds the enable, master/slave select and the receive interrupt enable. A status/configuration register holds the sticky event flags next to the mode-fault enable, the error interrupt enable and a two-bit rate select. A data register takes the byte to send when written and returns the last received byte when read. As master, the block makes the serial clock from the bus clock and shifts one byte per transfer, most significant bit first. As slave, it shifts on an external serial clock while its select input is low.

Clearing the enable bit works as a partial reset. Any transfer in progress stops and the shift path returns to idle. The configuration and the pending flags are kept, so software can still service them and restart without programming the block again. A receive overflow is decided at one exact point: the capture of bit 1 of the next byte, halfway through the seventh serial clock cycle. While overflow is pending, later bytes are dropped. A select level that is wrong for the configured mode is a mode fault. In master mode, a mode fault turns the block off. Receive-full, overflow and mode fault share a single interrupt request. A single output-enable signal shows whether the serial pins belong to the block.

Top module: `spi_err_ctrl`

## Requirements
- R1: After a system reset the control register reads 0x00, the status register reads 0x08 (only the transmit-empty flag set), the data register reads 0x00, and `irq`, `pin_oe` and `sck_o` are 0.
- R2: While the enable bit (control bit 0) is 0, transmit-empty reads 1, `pin_oe` is 0, `sck_o` is idle low and any transfer in progress is aborted. The bit counter and shift register restart, so the next transfer after re-enabling moves a complete, correct byte.
- R3: Clearing the enable bit changes nothing else: master select (control bit 1) and receive interrupt enable (control bit 2) are kept. In the status register the same holds for error interrupt enable (bit 6), mode-fault enable (bit 2), rate select (bits 1:0) and the flags receive-full (bit 7), overflow (bit 5) and mode-fault (bit 4). Bit 3 of the status register is transmit-empty. Control is at address 0, status at 1 and data at 2.
- R4: Overflow is set when receive-full is still 1 at the capture of the seventh bit of the next byte (the seventh rising serial clock edge). A data read that clears receive-full before that edge avoids overflow, and the new byte is then received normally.
- R5: While overflow is 1, a completed byte is not written to the data register and does not set receive-full. The earlier byte stays readable.
- R6: Receive-full and overflow are each cleared by a status read that returns the flag as 1 followed by a data register read. A data read with no such status read before it leaves receive-full set.
- R7: `irq` is 1 exactly when (receive-full and receive interrupt enable) or (error interrupt enable and (overflow or mode-fault)).
- R8: With mode-fault enable at 0 the mode-fault flag is never set, whatever the select input does.
- R9: In master mode with mode-fault enable set, a low level on `ss_n_i` sets mode-fault and clears the enable bit, which disables the block.
- R10: Mode-fault is cleared by a status read that returns it as 1 followed by a control register write.
- R11: As master, the serial clock period is 2, 8, 32 or 128 bus clocks for rate select 0 to 3. Data goes out most significant bit first, and a transfer is 8 serial clock cycles.
- R12: As slave, the block loads the pending byte when `ss_n_i` goes low and shifts on `sck_i` (capture on the rising edge, output change on the falling edge). It reports a mode fault, with the enable bit kept, when `ss_n_i` goes high mid-transfer while mode-fault enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| wr | input | 1 | Register write strobe |
| rd | input | 1 | Register read strobe (read side effects) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Combined receive/error interrupt request |
| pin_oe | output | 1 | Serial pins are owned by the block |
| sck_o | output | 1 | Serial clock out (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_o | output | 1 | Serial data out (slave) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Master transfers are run with varied byte values at two rates. They show that the bit order and the serial clock period are correct and that each byte lands in the right register. The overflow check is run twice with the previous byte still unread. In one run the byte is read in the half cycle just before the seventh capture edge. In the other it is read only after that edge. The two runs separate a strobe placed on the right edge from one placed a bit early or late. The enable bit is toggled with flags pending and again in the middle of a transfer, which separates the partial reset from a full one. The select input is driven low with mode-fault enable off and then on, and pulled high during a slave transfer. These runs separate the master fault, which disables the block, from the slave fault, which leaves it enabled.

// File: rtl/spi_err_pkg.sv
package spi_err_pkg;
  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int unsigned C_EN   = 0;
  localparam int unsigned C_MSTR = 1;
  localparam int unsigned C_RXIE = 2;

  // status/configuration register bit positions
  localparam int unsigned S_RXF   = 7;
  localparam int unsigned S_ERRIE = 6;
  localparam int unsigned S_OVF   = 5;
  localparam int unsigned S_MDF   = 4;
  localparam int unsigned S_TXE   = 3;
  localparam int unsigned S_MFEN  = 2;
  localparam int unsigned S_RATE  = 0;
endpackage

// File: rtl/spi_err_clkdiv.sv
module spi_err_clkdiv #(
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  localparam int unsigned CW = 2 * ((1 << RATE_W) - 1) + 1;

  logic [CW-1:0] cnt_q, cnt_d, half_m1;

  always_comb begin
    half_m1 = (CW'(1) << {rate, 1'b0}) - CW'(1);
    cnt_d   = cnt_q;
    tick    = 1'b0;
    if (!run) begin
      cnt_d = '0;
    end else if (cnt_q == half_m1) begin
      cnt_d = '0;
      tick  = 1'b1;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_err_shifter.sv
module spi_err_shifter #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          master,
  input  logic          start,
  input  logic [DW-1:0] load_data,
  input  logic          tick,
  input  logic          sck_i,
  input  logic          sdi,
  input  logic          ss_n_i,
  output logic          busy,
  output logic          sck_o,
  output logic          sdo,
  output logic          slv_rdy,
  output logic          strobe_b1,
  output logic          done,
  output logic [DW-1:0] rx_byte
);
  localparam int unsigned CNT_W = $clog2(DW + 1);

  logic [DW-1:0]    sh_q, sh_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, sck_q, sck_d, samp_q, samp_d;
  logic             sin_q, sin_d, rdy_q, rdy_d;
  logic             rise, fall;

  always_comb begin
    rise      = master ? (tick & ~sck_q) : (sck_i & ~sin_q);
    fall      = master ? (tick &  sck_q) : (~sck_i & sin_q);
    sh_d      = sh_q;
    cnt_d     = cnt_q;
    busy_d    = busy_q;
    sck_d     = sck_q;
    samp_d    = samp_q;
    sin_d     = sck_i;
    rdy_d     = rdy_q;
    strobe_b1 = 1'b0;
    done      = 1'b0;
    if (!en) begin
      sh_d   = '0;
      cnt_d  = '0;
      busy_d = 1'b0;
      sck_d  = 1'b0;
      samp_d = 1'b0;
      rdy_d  = 1'b0;
    end else if (!busy_q) begin
      sck_d = 1'b0;
      if (ss_n_i) rdy_d = 1'b1;
      if (start) begin
        sh_d   = load_data;
        cnt_d  = '0;
        busy_d = 1'b1;
        rdy_d  = 1'b0;
      end
    end else if (!master && ss_n_i) begin
      sh_d   = '0;
      cnt_d  = '0;
      busy_d = 1'b0;
    end else if (rise && cnt_q != CNT_W'(DW)) begin
      samp_d = sdi;
      cnt_d  = cnt_q + CNT_W'(1);
      if (master) sck_d = 1'b1;
      if (cnt_q == CNT_W'(DW - 2)) strobe_b1 = 1'b1;
      if (cnt_q == CNT_W'(DW - 1)) done = 1'b1;
    end else if (fall) begin
      if (master) sck_d = 1'b0;
      if (cnt_q == CNT_W'(DW)) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        sh_d = {sh_q[DW-2:0], samp_q};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      sin_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      sck_q  <= sck_d;
      samp_q <= samp_d;
      sin_q  <= sin_d;
      rdy_q  <= rdy_d;
    end
  end

  assign busy    = busy_q;
  assign sck_o   = sck_q;
  assign sdo     = sh_q[DW-1];
  assign slv_rdy = rdy_q;
  assign rx_byte = {sh_q[DW-2:0], sdi};
endmodule

// File: rtl/spi_err_regs.sv
module spi_err_regs
  import spi_err_pkg::*;
#(
  parameter int unsigned DW     = 8,
  parameter int unsigned RATE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DW-1:0]     wdata,
  input  logic              busy,
  input  logic              start,
  input  logic              done,
  input  logic              strobe_b1,
  input  logic [DW-1:0]     rx_byte,
  input  logic              ss_n_i,
  output logic [DW-1:0]     rdata,
  output logic              en,
  output logic              master,
  output logic              rxie,
  output logic              errie,
  output logic              mfen,
  output logic [RATE_W-1:0] rate,
  output logic              txe,
  output logic [DW-1:0]     txbuf,
  output logic              rxfull,
  output logic              ovf,
  output logic              mdf,
  output logic [DW-1:0]     rx_q,
  output logic              irq
);
  logic en_q, en_d, mstr_q, mstr_d, rxie_q, rxie_d, errie_q, errie_d, mfen_q, mfen_d;
  logic rxf_q, rxf_d, ovf_q, ovf_d, mdf_q, mdf_d, txe_q, txe_d;
  logic arm_rx_q, arm_rx_d, arm_ov_q, arm_ov_d, arm_mf_q, arm_mf_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [DW-1:0]     txb_q, txb_d, rx_d;
  logic wr_ctrl, wr_stat, wr_data, rd_stat, rd_data, fault_m, fault_s;

  always_comb begin
    wr_ctrl = wr && (reg_addr_e'(addr) == A_CTRL);
    wr_stat = wr && (reg_addr_e'(addr) == A_STAT);
    wr_data = wr && (reg_addr_e'(addr) == A_DATA);
    rd_stat = rd && (reg_addr_e'(addr) == A_STAT);
    rd_data = rd && (reg_addr_e'(addr) == A_DATA);
    fault_m = en_q &  mstr_q & mfen_q & ~ss_n_i;
    fault_s = en_q & ~mstr_q & mfen_q & busy & ss_n_i;

    en_d = en_q; mstr_d = mstr_q; rxie_d = rxie_q;
    errie_d = errie_q; mfen_d = mfen_q; rate_d = rate_q;
    rxf_d = rxf_q; ovf_d = ovf_q; mdf_d = mdf_q; txe_d = txe_q;
    arm_rx_d = arm_rx_q; arm_ov_d = arm_ov_q; arm_mf_d = arm_mf_q;
    txb_d = txb_q; rx_d = rx_q;

    if (wr_ctrl) begin
      en_d   = wdata[C_EN];
      mstr_d = wdata[C_MSTR];
      rxie_d = wdata[C_RXIE];
      if (arm_mf_q) mdf_d = 1'b0;
      arm_mf_d = 1'b0;
    end
    if (wr_stat) begin
      errie_d = wdata[S_ERRIE];
      mfen_d  = wdata[S_MFEN];
      rate_d  = wdata[S_RATE +: RATE_W];
    end
    if (rd_stat) begin
      arm_rx_d = rxf_q;
      arm_ov_d = ovf_q;
      arm_mf_d = mdf_q;
    end
    if (rd_data) begin
      if (arm_rx_q) rxf_d = 1'b0;
      if (arm_ov_q) ovf_d = 1'b0;
      arm_rx_d = 1'b0;
      arm_ov_d = 1'b0;
    end
    if (strobe_b1 && rxf_q) ovf_d = 1'b1;
    if (done && !ovf_q) begin
      rxf_d = 1'b1;
      rx_d  = rx_byte;
    end
    if (fault_m) en_d = 1'b0;
    if (fault_m || fault_s) mdf_d = 1'b1;

    if (!en_q) begin
      txe_d = 1'b1;
    end else if (wr_data) begin
      txe_d = 1'b0;
      txb_d = wdata;
    end else if (start) begin
      txe_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; mstr_q <= 1'b0; rxie_q <= 1'b0;
      errie_q <= 1'b0; mfen_q <= 1'b0; rate_q <= '0;
      rxf_q <= 1'b0; ovf_q <= 1'b0; mdf_q <= 1'b0; txe_q <= 1'b1;
      arm_rx_q <= 1'b0; arm_ov_q <= 1'b0; arm_mf_q <= 1'b0;
      txb_q <= '0; rx_q <= '0;
    end else begin
      en_q <= en_d; mstr_q <= mstr_d; rxie_q <= rxie_d;
      errie_q <= errie_d; mfen_q <= mfen_d; rate_q <= rate_d;
      rxf_q <= rxf_d; ovf_q <= ovf_d; mdf_q <= mdf_d; txe_q <= txe_d;
      arm_rx_q <= arm_rx_d; arm_ov_q <= arm_ov_d; arm_mf_q <= arm_mf_d;
      txb_q <= txb_d; rx_q <= rx_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (reg_addr_e'(addr))
      A_CTRL: begin
        rdata[C_EN]   = en_q;
        rdata[C_MSTR] = mstr_q;
        rdata[C_RXIE] = rxie_q;
      end
      A_STAT: begin
        rdata[S_RXF]   = rxf_q;
        rdata[S_ERRIE] = errie_q;
        rdata[S_OVF]   = ovf_q;
        rdata[S_MDF]   = mdf_q;
        rdata[S_TXE]   = txe_q;
        rdata[S_MFEN]  = mfen_q;
        rdata[S_RATE +: RATE_W] = rate_q;
      end
      A_DATA:  rdata = rx_q;
      default: rdata = '0;
    endcase
  end

  assign en     = en_q;
  assign master = mstr_q;
  assign rxie   = rxie_q;
  assign errie  = errie_q;
  assign mfen   = mfen_q;
  assign rate   = rate_q;
  assign txe    = txe_q;
  assign txbuf  = txb_q;
  assign rxfull = rxf_q;
  assign ovf    = ovf_q;
  assign mdf    = mdf_q;
  assign irq    = (rxf_q & rxie_q) | (errie_q & (ovf_q | mdf_q));
endmodule

// File: rtl/spi_err_ctrl.sv
module spi_err_ctrl #(
  parameter int unsigned DW     = 8,
  parameter int unsigned RATE_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq,
  output logic          pin_oe,
  output logic          sck_o,
  output logic          mosi_o,
  output logic          miso_o,
  input  logic          sck_i,
  input  logic          mosi_i,
  input  logic          miso_i,
  input  logic          ss_n_i
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  logic              en, master, rxie, errie, mfen, txe, rxfull, ovf, mdf;
  logic [RATE_W-1:0] rate;
  logic [DW-1:0]     txbuf, rx_q, rx_byte;
  logic              busy, tick, sdo, slv_rdy, strobe_b1, done, start, sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  assign start = en & ~busy & (master ? ~txe : (~ss_n_i & slv_rdy));
  assign sdi   = master ? miso_i : mosi_i;

  spi_err_regs #(.DW(DW), .RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .busy(busy), .start(start), .done(done), .strobe_b1(strobe_b1),
    .rx_byte(rx_byte), .ss_n_i(ss_n_i), .rdata(rdata), .en(en),
    .master(master), .rxie(rxie), .errie(errie), .mfen(mfen), .rate(rate),
    .txe(txe), .txbuf(txbuf), .rxfull(rxfull), .ovf(ovf), .mdf(mdf),
    .rx_q(rx_q), .irq(irq)
  );

  spi_err_clkdiv #(.RATE_W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n_s), .run(busy & master & en), .rate(rate), .tick(tick)
  );

  spi_err_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n_s), .en(en), .master(master), .start(start),
    .load_data(txbuf), .tick(tick), .sck_i(sck_i), .sdi(sdi), .ss_n_i(ss_n_i),
    .busy(busy), .sck_o(sck_o), .sdo(sdo), .slv_rdy(slv_rdy),
    .strobe_b1(strobe_b1), .done(done), .rx_byte(rx_byte)
  );

  assign pin_oe = en;
  assign mosi_o = en &  master & sdo;
  assign miso_o = en & ~master & sdo;
endmodule

// File: rtl/spi_err_ctrl_chk.sv
module spi_err_ctrl_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n_s,
  input logic [1:0]    addr,
  input logic          wr,
  input logic          en,
  input logic          master,
  input logic          txe,
  input logic          busy,
  input logic          sck_o,
  input logic          rxfull,
  input logic          ovf,
  input logic          mdf,
  input logic          mfen,
  input logic          errie,
  input logic          rxie,
  input logic          strobe_b1,
  input logic          done,
  input logic [DW-1:0] rx_q,
  input logic          irq
);
  p_off_idle_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    !en |=> (!busy && txe));

  p_ovf_at_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ovf) |-> $past(strobe_b1 && rxfull));

  p_no_load_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (done && ovf) |=> (rx_q == $past(rx_q)));

  p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!errie && !rxie) |-> !irq);

  p_mfen_gate_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(mdf) |-> $past(mfen));

  p_fault_off_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($rose(mdf) && $past(master)) |-> !en);

  p_mdf_clear_r10: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(mdf) |-> $past(wr && addr == 2'd0));

  p_sck_idle_r11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !sck_o);
endmodule

bind spi_err_ctrl spi_err_ctrl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .addr(addr), .wr(wr), .en(en),
  .master(master), .txe(txe), .busy(busy), .sck_o(sck_o), .rxfull(rxfull),
  .ovf(ovf), .mdf(mdf), .mfen(mfen), .errie(errie), .rxie(rxie),
  .strobe_b1(strobe_b1), .done(done), .rx_q(rx_q), .irq(irq)
);

// File: tb/tb_spi_err_ctrl.sv
module tb_spi_err_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n;
  logic [1:0] addr;
  logic       wr, rd;
  logic [7:0] wdata, rdata;
  logic       irq, pin_oe, sck_o, mosi_o, miso_o;
  logic       sck_i, mosi_i, miso_i, ss_n_i;

  spi_err_ctrl dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr(wr), .rd(rd), .wdata(wdata),
    .rdata(rdata), .irq(irq), .pin_oe(pin_oe), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_o(miso_o), .sck_i(sck_i), .mosi_i(mosi_i), .miso_i(miso_i),
    .ss_n_i(ss_n_i)
  );

  typedef struct {
    logic [7:0] val;
    logic [7:0] mask;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int rises = 0, falls = 0, rbase = 0, fbase = 0;
  int last_rise = 0, prev_rise = 0;
  logic [7:0] slv_byte = 8'h00;
  logic [7:0] mosi_cap = 8'h00;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, got cycle %0d expected end", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // bus-side peripheral model for master transfers
  assign miso_i = slv_byte[3'(7 - (falls - fbase))];
  always @(posedge sck_o) begin
    mosi_cap  = {mosi_cap[6:0], mosi_o};
    prev_rise = last_rise;
    last_rise = cyc;
    rises     = rises + 1;
  end
  always @(negedge sck_o) falls = falls + 1;

  // monitor: pops expected read values and compares
  always @(negedge clk) begin
    #1;
    if (rd) begin
      if (sbq.size() == 0) begin
        n_cmp = n_cmp + 1; n_bad = n_bad + 1;
        $display("FAIL scoreboard empty: got %02h expected nothing", rdata);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp = n_cmp + 1;
        if ((rdata & e.mask) !== (e.val & e.mask)) begin
          n_bad = n_bad + 1;
          $display("FAIL %s: got %02h expected %02h", e.tag, rdata & e.mask, e.val & e.mask);
        end
      end
    end
  end

  task automatic rd_exp(input logic [1:0] a, input logic [7:0] e, input string tag);
    sbq.push_back('{e, 8'hFF, tag});
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic chk(input string tag, input int got, input int exp);
    #1;
    n_cmp = n_cmp + 1;
    if (got !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic mstart(input logic [7:0] tx, input logic [7:0] ret);
    slv_byte = ret; fbase = falls; rbase = rises;
    wr_reg(2'd2, tx);
  endtask

  task automatic mwait_end();
    wait (rises - rbase == 8);
    @(negedge sck_o);
    repeat (3) @(negedge clk);
  endtask

  task automatic mxfer(input logic [7:0] tx, input logic [7:0] ret);
    mstart(tx, ret);
    mwait_end();
  endtask

  task automatic sbyte(input logic [7:0] b, input int nbits, output logic [7:0] cap);
    cap = 8'h00;
    for (int i = 7; i > 7 - nbits; i--) begin
      @(negedge clk); mosi_i = b[i];
      repeat (2) @(negedge clk); sck_i = 1'b1; cap = {cap[6:0], miso_o};
      repeat (3) @(negedge clk); sck_i = 1'b0;
      repeat (2) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] scap;
    rst_n = 1'b0; addr = 2'd0; wr = 1'b0; rd = 1'b0; wdata = 8'h00;
    sck_i = 1'b0; mosi_i = 1'b0; ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd_exp(2'd0, 8'h00, "R1 ctrl reset");
    rd_exp(2'd1, 8'h08, "R1 status reset");
    rd_exp(2'd2, 8'h00, "R1 data reset");
    chk("R1 irq reset", irq, 0);
    chk("R1 pin_oe reset", pin_oe, 0);
    chk("R1 sck reset", sck_o, 0);

    // basic master transfer, fastest rate
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h07);
    chk("R2 pin_oe enabled", pin_oe, 1);
    mxfer(8'hA5, 8'h3C);
    chk("R11 msb-first out", mosi_cap, 8'hA5);
    chk("R7 irq on rx full", irq, 1);
    rd_exp(2'd1, 8'h88, "R6 status full");
    rd_exp(2'd2, 8'h3C, "R11 rx byte");
    rd_exp(2'd1, 8'h08, "R6 rx full cleared");
    chk("R7 irq idle", irq, 0);

    // R6 data read without a status read first does not clear
    mxfer(8'h0F, 8'hF0);
    rd_exp(2'd2, 8'hF0, "R6 data bare read");
    rd_exp(2'd1, 8'h88, "R6 still full");
    rd_exp(2'd2, 8'hF0, "R6 data read");
    rd_exp(2'd1, 8'h08, "R6 cleared");

    // R11 rate select 2 -> 32 bus clocks per serial cycle
    wr_reg(2'd1, 8'h02);
    mxfer(8'h81, 8'h18);
    chk("R11 period rate2", last_rise - prev_rise, 32);
    chk("R11 out rate2", mosi_cap, 8'h81);
    rd_exp(2'd1, 8'h8A, "R11 status");
    rd_exp(2'd2, 8'h18, "R11 rx rate2");

    // R4 read just before the bit-1 strobe: no overflow
    wr_reg(2'd1, 8'h43);
    mxfer(8'h11, 8'h11);
    mstart(8'h22, 8'h22);
    wait (rises - rbase == 6);
    @(negedge sck_o);
    rd_exp(2'd1, 8'hCB, "R4 status before strobe");
    rd_exp(2'd2, 8'h11, "R4 old byte");
    mwait_end();
    rd_exp(2'd1, 8'hCB, "R4 no overflow");
    rd_exp(2'd2, 8'h22, "R4 new byte loaded");

    // R4/R5 read only after the strobe: overflow, new byte dropped
    mxfer(8'h33, 8'h33);
    mxfer(8'h44, 8'h44);
    rd_exp(2'd1, 8'hEB, "R4 overflow set");
    chk("R7 irq overflow", irq, 1);
    wr_reg(2'd0, 8'h03);
    chk("R7 irq errie only", irq, 1);
    wr_reg(2'd1, 8'h03);
    chk("R7 irq masked", irq, 0);
    wr_reg(2'd1, 8'h43);

    // R3 enable toggle keeps config and flags
    wr_reg(2'd0, 8'h02);
    chk("R2 pin_oe off", pin_oe, 0);
    rd_exp(2'd0, 8'h02, "R3 ctrl kept");
    rd_exp(2'd1, 8'hEB, "R3 flags kept");
    wr_reg(2'd0, 8'h07);
    rd_exp(2'd1, 8'hEB, "R3 flags after enable");
    rd_exp(2'd2, 8'h33, "R5 old byte kept");
    rd_exp(2'd1, 8'h4B, "R6 overflow cleared");

    // R2 abort mid-transfer, then a full byte
    wr_reg(2'd1, 8'h02);
    mstart(8'h96, 8'h00);
    wait (rises - rbase == 3);
    wr_reg(2'd0, 8'h06);
    repeat (2) @(negedge clk);
    chk("R2 sck idle after abort", sck_o, 0);
    rd_exp(2'd1, 8'h0A, "R2 txe set when off");
    wr_reg(2'd0, 8'h07);
    repeat (40) @(negedge clk);
    rd_exp(2'd1, 8'h0A, "R2 no restart");
    mxfer(8'h96, 8'h69);
    chk("R2 full byte out", mosi_cap, 8'h96);
    rd_exp(2'd1, 8'h8A, "R2 status after");
    rd_exp(2'd2, 8'h69, "R2 full byte in");

    // R8 fault gated off
    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    rd_exp(2'd0, 8'h07, "R8 still enabled");
    rd_exp(2'd1, 8'h0A, "R8 no mode fault");
    ss_n_i = 1'b1;

    // R9 master mode fault disables
    wr_reg(2'd1, 8'h46);
    ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 pin_oe dropped", pin_oe, 0);
    rd_exp(2'd0, 8'h06, "R9 enable cleared");
    rd_exp(2'd1, 8'h5E, "R9 fault flag");
    chk("R7 irq on fault", irq, 1);
    ss_n_i = 1'b1;
    wr_reg(2'd0, 8'h07);
    rd_exp(2'd1, 8'h4E, "R10 fault cleared");
    rd_exp(2'd0, 8'h07, "R10 re-enabled");

    // R12 slave transfer
    wr_reg(2'd0, 8'h05);
    wr_reg(2'd2, 8'h5A);
    @(negedge clk); ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    sbyte(8'hC3, 8, scap);
    repeat (2) @(negedge clk); ss_n_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R12 slave out", scap, 8'h5A);
    rd_exp(2'd1, 8'hCE, "R12 slave status");
    rd_exp(2'd2, 8'hC3, "R12 slave in");

    // R12 slave mode fault keeps enable
    @(negedge clk); ss_n_i = 1'b0;
    repeat (3) @(negedge clk);
    sbyte(8'hFF, 3, scap);
    ss_n_i = 1'b1;
    repeat (3) @(negedge clk);
    rd_exp(2'd1, 8'h5E, "R12 slave fault");
    rd_exp(2'd0, 8'h05, "R12 enable kept");
    chk("R12 pin_oe kept", pin_oe, 1);

    repeat (4) @(negedge clk);
    if (sbq.size() != 0) begin
      n_cmp = n_cmp + 1; n_bad = n_bad + 1;
      $display("FAIL scoreboard leftover: got %0d expected 0", sbq.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule